// File: doc/BRIEF.md
# PRBS Bit Error Rate Tester

This block exercises a serial link with a maximal-length pseudo-random bit stream and measures how many bits come back wrong. The transmit side is a linear feedback shift register of selectable length. It can run the sequence in the normal or in the time-reversed direction, and it can corrupt single bits on request. The receive side needs no reference from the transmitter. It learns the incoming sequence from the bits themselves, declares sync, and then predicts every following bit with its own free-running register. Each received bit that differs from the prediction is an error.

After sync is declared, a programmable number of bits is skipped. Error and bit totals then build up over a window of ten to the power three up to ten to the power nine bits, or without limit. At the end of a window, the totals are frozen on the outputs and the live counters start again from zero.

Both data directions use a valid/ready handshake. The generator holds `tx_valid` high from the first cycle after reset. It keeps `tx_data` unchanged for as long as `tx_ready` is low, and it moves to the next bit only on a cycle where valid and ready are both high. The receiver never applies back-pressure: `rx_ready` is always high, and each cycle with `rx_valid` high delivers one bit.

Top module: `prbs_link_tester`

## Requirements
- R1: `cfg_pattern` selects the sequence length n and the tap k: 0 gives n=7, k=6; 1 gives n=9, k=5; 2 gives n=11, k=9; 3 gives n=15, k=14. With `cfg_reverse` low, every transmitted bit a(t), from the n-th bit on, equals a(t-n) XOR a(t-k).
- R2: With `cfg_reverse` high, the sequence uses the reciprocal polynomial: a(t) = a(t-n) XOR a(t-(n-k)).
- R3: On a clean stream, `sync` rises after at least 2n and at most 3n received bits, counted from reset or from a loss of sync. It rises only on the clock edge that follows a received bit.
- R4: Bits received while `sync` is low are not counted. The first B bits received while `sync` is high are counted neither as bits nor as errors, where `cfg_blank` 0 gives B=32, 1 gives B=64, and 2 or 3 gives B=128.
- R5: Every later received bit increments the bit count by one. A bit that differs from the receiver's own prediction also increments the error count by one, so a single corrupted bit counts as exactly one error.
- R6: `cfg_window` w from 0 to 6 sets a window of 10^(3+w) counted bits. On the edge that counts the last bit of the window, the totals are latched onto `bit_count` and `err_count`, the live counters clear, and `period_done` is high for one cycle. With w=7 the outputs show the live counters and `period_done` stays low.
- R7: Each rising edge of `force_err` inverts exactly one later transmitted bit and leaves the sequence otherwise intact. A locked receiver therefore counts exactly one error per edge.
- R8: Locked bits are grouped into blocks of 64, starting at the moment of sync. Eight errors in one block keep `sync` high. A ninth error in the same block drops `sync` on the edge that receives it, and the receiver then reacquires from the incoming bits.
- R9: Both counters saturate at 2^CNT_W-1 and never wrap.
- R10: While `tx_valid` is high and `tx_ready` is low, `tx_data` holds its value. `tx_valid` is high from the first edge after reset, and `rx_ready` is always high.
- R11: During and just after reset, `sync`, `period_done`, `err_count` and `bit_count` are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_pattern | input | 2 | Sequence length select |
| cfg_reverse | input | 1 | Use the reciprocal polynomial |
| cfg_blank | input | 2 | Blanking span after sync |
| cfg_window | input | 3 | Decade window select, 7 for continuous |
| force_err | input | 1 | Rising edge corrupts one transmitted bit |
| tx_valid | output | 1 | Transmit bit available |
| tx_ready | input | 1 | Link accepts the transmit bit |
| tx_data | output | 1 | Transmit bit |
| rx_valid | input | 1 | Receive bit present |
| rx_ready | output | 1 | Always high |
| rx_data | input | 1 | Receive bit |
| sync | output | 1 | Receiver locked to the sequence |
| err_count | output | CNT_W | Error total, latched or live |
| bit_count | output | CNT_W | Bit total, latched or live |
| period_done | output | 1 | One-cycle pulse at the end of a window |

## Verification
The assertions run on every cycle and check the following: transmit data stays stable under back-pressure, nothing is counted while unsynced, the continuous count grows by at most one bit per cycle, errors never exceed bits, and window pulses are isolated and absent in continuous mode. Some properties can only be shown by the bench's scenarios, because they depend on the stream as a whole: the recurrence of the transmitted sequence for every length and direction, the acquisition latency, the exact blanking boundary, the window totals, single-bit forced errors, the nine-in-a-block loss threshold with reacquisition, and saturation on a narrow counter instance.

// File: rtl/prbs_bert_pkg.sv
`timescale 1ns/1ps
package prbs_bert_pkg;

  localparam int unsigned SR_W      = 15;
  localparam int unsigned MAX_BLANK = 128;

  typedef enum logic [1:0] {
    PAT_7  = 2'd0,
    PAT_9  = 2'd1,
    PAT_11 = 2'd2,
    PAT_15 = 2'd3
  } pat_e;

  function automatic logic [4:0] pat_len(pat_e p);
    case (p)
      PAT_7:   return 5'd7;
      PAT_9:   return 5'd9;
      PAT_11:  return 5'd11;
      default: return 5'd15;
    endcase
  endfunction

  // next bit of the recurrence; s[0] is the newest bit
  function automatic logic lfsr_next(logic [SR_W-1:0] s, pat_e p, logic rev);
    case (p)
      PAT_7:   return s[6]  ^ (rev ? s[0] : s[5]);
      PAT_9:   return s[8]  ^ (rev ? s[3] : s[4]);
      PAT_11:  return s[10] ^ (rev ? s[1] : s[8]);
      default: return s[14] ^ (rev ? s[0] : s[13]);
    endcase
  endfunction

  function automatic logic [SR_W-1:0] len_mask(pat_e p);
    return (SR_W'(1) << pat_len(p)) - SR_W'(1);
  endfunction

  function automatic logic [7:0] blank_len(logic [1:0] sel);
    case (sel)
      2'd0:    return 8'd32;
      2'd1:    return 8'd64;
      default: return 8'(MAX_BLANK);
    endcase
  endfunction

  function automatic logic [63:0] window_limit(logic [2:0] w);
    logic [63:0] lim;
    lim = 64'd1000;
    for (int i = 0; i < 6; i++) begin
      if (i < int'(w)) lim = lim * 64'd10;
    end
    return lim;
  endfunction

endpackage

// File: rtl/prbs_tx_gen.sv
`timescale 1ns/1ps
module prbs_tx_gen
  import prbs_bert_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  pat_e pat,
  input  logic rev,
  input  logic force_req,
  output logic tx_valid,
  input  logic tx_ready,
  output logic tx_data
);

  logic [SR_W-1:0] hist;
  logic            valid_q;
  logic            flip_q;
  logic            pend_q;
  logic            req_q;
  logic            fire;
  logic            req_edge;
  logic            stuck;
  logic            nb;

  assign fire     = valid_q && tx_ready;
  assign req_edge = force_req && !req_q;
  assign stuck    = (hist & len_mask(pat)) == '0;
  assign nb       = stuck ? 1'b1 : lfsr_next(hist, pat, rev);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hist    <= '1;
      valid_q <= 1'b0;
      flip_q  <= 1'b0;
      pend_q  <= 1'b0;
      req_q   <= 1'b0;
    end else begin
      valid_q <= 1'b1;
      req_q   <= force_req;
      if (fire) begin
        hist   <= {hist[SR_W-2:0], nb};
        flip_q <= pend_q | req_edge;
        pend_q <= 1'b0;
      end else if (req_edge) begin
        pend_q <= 1'b1;
      end
    end
  end

  assign tx_valid = valid_q;
  assign tx_data  = hist[0] ^ flip_q;

endmodule

// File: rtl/prbs_rx_sync.sv
`timescale 1ns/1ps
module prbs_rx_sync
  import prbs_bert_pkg::*;
#(
  parameter int unsigned LOSS_WIN = 64,
  parameter int unsigned LOSS_MAX = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  pat_e pat,
  input  logic rev,
  input  logic rx_valid,
  input  logic rx_data,
  output logic locked,
  output logic bit_stb,
  output logic bit_err
);

  localparam int unsigned POS_W = $clog2(LOSS_WIN);
  localparam int unsigned ERR_W = $clog2(LOSS_MAX + 1);
  localparam int unsigned HIT_W = $clog2(2 * SR_W + 1);

  logic [SR_W-1:0]  shreg;
  logic             locked_q;
  logic [HIT_W-1:0] hits;
  logic [HIT_W-1:0] hit_goal;
  logic [POS_W-1:0] blk_pos;
  logic [ERR_W-1:0] blk_errs;
  logic             pred;
  logic             mism;
  logic             blk_last;
  logic             too_many;

  assign pred     = lfsr_next(shreg, pat, rev);
  assign mism     = pred ^ rx_data;
  assign hit_goal = HIT_W'({pat_len(pat), 1'b0});
  assign blk_last = blk_pos == POS_W'(LOSS_WIN - 1);
  assign too_many = mism && (blk_errs == ERR_W'(LOSS_MAX));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      shreg    <= '0;
      locked_q <= 1'b0;
      hits     <= '0;
      blk_pos  <= '0;
      blk_errs <= '0;
    end else if (rx_valid) begin
      if (!locked_q) begin
        // hunt: history follows the line, predictions are scored
        shreg <= {shreg[SR_W-2:0], rx_data};
        if (mism) begin
          hits <= '0;
        end else if (hits == hit_goal - HIT_W'(1)) begin
          locked_q <= 1'b1;
          hits     <= '0;
          blk_pos  <= '0;
          blk_errs <= '0;
        end else begin
          hits <= hits + HIT_W'(1);
        end
      end else begin
        // locked: free-running, line errors do not enter the register
        shreg <= {shreg[SR_W-2:0], pred};
        if (too_many) begin
          locked_q <= 1'b0;
          hits     <= '0;
        end else if (blk_last) begin
          blk_pos  <= '0;
          blk_errs <= '0;
        end else begin
          blk_pos <= blk_pos + POS_W'(1);
          if (mism) blk_errs <= blk_errs + ERR_W'(1);
        end
      end
    end
  end

  assign locked  = locked_q;
  assign bit_stb = locked_q && rx_valid;
  assign bit_err = locked_q && rx_valid && mism;

endmodule

// File: rtl/bert_accum.sv
`timescale 1ns/1ps
module bert_accum
  import prbs_bert_pkg::*;
#(
  parameter int unsigned CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [1:0]       blank_sel,
  input  logic [2:0]       window_sel,
  input  logic             locked,
  input  logic             bit_stb,
  input  logic             bit_err,
  output logic [CNT_W-1:0] err_count,
  output logic [CNT_W-1:0] bit_count,
  output logic             period_done
);

  localparam int unsigned    BLANK_W = $clog2(MAX_BLANK + 1);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic [BLANK_W-1:0] blank_cnt;
  logic               blank_done;
  logic               continuous;
  logic               count_stb;
  logic               window_end;
  logic               pd_q;
  logic [CNT_W-1:0]   live_bits, live_errs;
  logic [CNT_W-1:0]   held_bits, held_errs;
  logic [CNT_W-1:0]   nxt_bits, nxt_errs;

  assign blank_done = 8'(blank_cnt) >= blank_len(blank_sel);
  assign continuous = window_sel == 3'd7;
  assign count_stb  = bit_stb && blank_done;
  assign nxt_bits   = (live_bits == CNT_MAX) ? live_bits : live_bits + CNT_W'(1);
  assign nxt_errs   = (!bit_err || live_errs == CNT_MAX) ? live_errs : live_errs + CNT_W'(1);
  assign window_end = !continuous && (64'(nxt_bits) == window_limit(window_sel));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      blank_cnt <= '0;
    end else if (!locked) begin
      blank_cnt <= '0;
    end else if (bit_stb && !blank_done) begin
      blank_cnt <= blank_cnt + BLANK_W'(1);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      live_bits <= '0;
      live_errs <= '0;
      held_bits <= '0;
      held_errs <= '0;
      pd_q      <= 1'b0;
    end else begin
      pd_q <= 1'b0;
      if (count_stb) begin
        if (window_end) begin
          held_bits <= nxt_bits;
          held_errs <= nxt_errs;
          live_bits <= '0;
          live_errs <= '0;
          pd_q      <= 1'b1;
        end else begin
          live_bits <= nxt_bits;
          live_errs <= nxt_errs;
        end
      end
    end
  end

  assign bit_count   = continuous ? live_bits : held_bits;
  assign err_count   = continuous ? live_errs : held_errs;
  assign period_done = pd_q;

endmodule

// File: rtl/prbs_link_tester.sv
`timescale 1ns/1ps
module prbs_link_tester
  import prbs_bert_pkg::*;
#(
  parameter int unsigned CNT_W    = 32,
  parameter int unsigned LOSS_WIN = 64,
  parameter int unsigned LOSS_MAX = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [1:0]       cfg_pattern,
  input  logic             cfg_reverse,
  input  logic [1:0]       cfg_blank,
  input  logic [2:0]       cfg_window,
  input  logic             force_err,
  output logic             tx_valid,
  input  logic             tx_ready,
  output logic             tx_data,
  input  logic             rx_valid,
  output logic             rx_ready,
  input  logic             rx_data,
  output logic             sync,
  output logic [CNT_W-1:0] err_count,
  output logic [CNT_W-1:0] bit_count,
  output logic             period_done
);

  pat_e pat;
  logic locked, bit_stb, bit_err;

  assign pat      = pat_e'(cfg_pattern);
  assign rx_ready = 1'b1;
  assign sync     = locked;

  prbs_tx_gen u_gen (
    .clk       (clk),
    .rst_n     (rst_n),
    .pat       (pat),
    .rev       (cfg_reverse),
    .force_req (force_err),
    .tx_valid  (tx_valid),
    .tx_ready  (tx_ready),
    .tx_data   (tx_data)
  );

  prbs_rx_sync #(.LOSS_WIN(LOSS_WIN), .LOSS_MAX(LOSS_MAX)) u_sync (
    .clk      (clk),
    .rst_n    (rst_n),
    .pat      (pat),
    .rev      (cfg_reverse),
    .rx_valid (rx_valid),
    .rx_data  (rx_data),
    .locked   (locked),
    .bit_stb  (bit_stb),
    .bit_err  (bit_err)
  );

  bert_accum #(.CNT_W(CNT_W)) u_acc (
    .clk         (clk),
    .rst_n       (rst_n),
    .blank_sel   (cfg_blank),
    .window_sel  (cfg_window),
    .locked      (locked),
    .bit_stb     (bit_stb),
    .bit_err     (bit_err),
    .err_count   (err_count),
    .bit_count   (bit_count),
    .period_done (period_done)
  );

endmodule

// File: rtl/prbs_link_tester_chk.sv
`timescale 1ns/1ps
module prbs_link_tester_chk #(
  parameter int unsigned CNT_W = 32
) (
  input logic             clk,
  input logic             rst_n,
  input logic [2:0]       cfg_window,
  input logic             tx_valid,
  input logic             tx_ready,
  input logic             tx_data,
  input logic             rx_valid,
  input logic             sync,
  input logic [CNT_W-1:0] err_count,
  input logic [CNT_W-1:0] bit_count,
  input logic             period_done
);

  AST_TX_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_valid && !tx_ready) |=> (tx_valid && $stable(tx_data))); // R10

  AST_SYNC_AFTER_BIT: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sync) |-> $past(rx_valid)); // R3

  AST_IDLE_NO_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
    (!sync && cfg_window == 3'd7) |=> (cfg_window != 3'd7 || $stable(bit_count))); // R4

  AST_ONE_BIT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_window == 3'd7 && $past(cfg_window) == 3'd7) |->
      (bit_count == $past(bit_count) || bit_count == $past(bit_count) + CNT_W'(1))); // R5

  AST_ERR_LE_BITS: assert property (@(posedge clk) disable iff (!rst_n)
    err_count <= bit_count); // R5

  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    period_done |=> !period_done); // R6

  AST_DONE_NOT_CONT: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_window == 3'd7 && $past(cfg_window) == 3'd7) |-> !period_done); // R6

endmodule

bind prbs_link_tester prbs_link_tester_chk #(.CNT_W(CNT_W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .cfg_window  (cfg_window),
  .tx_valid    (tx_valid),
  .tx_ready    (tx_ready),
  .tx_data     (tx_data),
  .rx_valid    (rx_valid),
  .sync        (sync),
  .err_count   (err_count),
  .bit_count   (bit_count),
  .period_done (period_done)
);

// File: tb/prbs_link_tester_bench.sv
`timescale 1ns/1ps
module prbs_link_tester_bench;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [1:0]  cfg_pattern = 2'd0;
  logic        cfg_reverse = 1'b0;
  logic [1:0]  cfg_blank = 2'd0;
  logic [2:0]  cfg_window = 3'd7;
  logic        force_err = 1'b0;
  logic        tx_ready = 1'b0;
  logic        flip_b = 1'b0;
  logic        tx_valid, tx_data, rx_valid, rx_data, rx_ready;
  logic        sync, period_done;
  logic [31:0] err_count, bit_count;
  logic        n_txv, n_txd, n_rxr, n_sync, n_pd;
  logic [7:0]  n_err, n_bits;

  assign rx_valid = tx_valid && tx_ready;
  assign rx_data  = tx_data ^ flip_b;

  always #4 clk = ~clk;

  prbs_link_tester u_prbs_link_tester (
    .clk(clk), .rst_n(rst_n), .cfg_pattern(cfg_pattern), .cfg_reverse(cfg_reverse),
    .cfg_blank(cfg_blank), .cfg_window(cfg_window), .force_err(force_err),
    .tx_valid(tx_valid), .tx_ready(tx_ready), .tx_data(tx_data),
    .rx_valid(rx_valid), .rx_ready(rx_ready), .rx_data(rx_data),
    .sync(sync), .err_count(err_count), .bit_count(bit_count), .period_done(period_done)
  );

  // narrow counters, continuous, shares the receive stream
  prbs_link_tester #(.CNT_W(8)) u_narrow (
    .clk(clk), .rst_n(rst_n), .cfg_pattern(cfg_pattern), .cfg_reverse(cfg_reverse),
    .cfg_blank(cfg_blank), .cfg_window(3'd7), .force_err(1'b0),
    .tx_valid(n_txv), .tx_ready(1'b1), .tx_data(n_txd),
    .rx_valid(rx_valid), .rx_ready(n_rxr), .rx_data(rx_data),
    .sync(n_sync), .err_count(n_err), .bit_count(n_bits), .period_done(n_pd)
  );

  int checks = 0, errors = 0;
  int lock_idx, tally, rx_total, hist_cnt, recur_bad, blank_b, n_b, k_b, stall;
  int flip_lo, flip_hi, snap_tally, snap_rx;
  bit flip_on;
  logic [14:0] txh;
  logic        s_sync, s_pd;
  logic [31:0] s_err, s_bits;
  logic [7:0]  s_nbits;

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk);
    #1;
    s_sync = sync; s_pd = period_done; s_err = err_count; s_bits = bit_count;
    s_nbits = n_bits; snap_tally = tally; snap_rx = rx_total;
    if (!s_sync) lock_idx = 0;
    stall++;
    tx_ready = (stall % 3) != 0;
    flip_b = flip_on && s_sync && lock_idx >= flip_lo && lock_idx <= flip_hi;
    #1;
    if (tx_valid && tx_ready) begin
      if (hist_cnt >= n_b && tx_data != (txh[n_b-1] ^ txh[k_b-1])) recur_bad++;
      txh = {txh[13:0], tx_data};
      hist_cnt++;
      rx_total++;
      if (s_sync) begin
        if (lock_idx >= blank_b) tally++;
        lock_idx++;
      end
    end
  endtask

  task automatic reset_dut(input int p, input bit r, input int b, input int w);
    rst_n = 1'b0;
    cfg_pattern = 2'(p); cfg_reverse = r; cfg_blank = 2'(b); cfg_window = 3'(w);
    force_err = 1'b0; flip_on = 1'b0;
    repeat (3) step();
    rst_n = 1'b1;
    lock_idx = 0; tally = 0; rx_total = 0; hist_cnt = 0; recur_bad = 0;
    blank_b = (b == 0) ? 32 : (b == 1) ? 64 : 128;
    n_b = (p == 0) ? 7 : (p == 1) ? 9 : (p == 2) ? 11 : 15;
    k_b = (p == 0) ? 6 : (p == 1) ? 5 : (p == 2) ? 9 : 14;
    if (r) k_b = n_b - k_b;
  endtask

  task automatic wait_sync(input int max_steps);
    for (int i = 0; i < max_steps && !s_sync; i++) step();
  endtask

  task automatic blank_run(input int b, input int at, input int exp_err, input string req);
    reset_dut(1, 1'b1, b, 7);
    flip_on = 1'b1; flip_lo = at; flip_hi = at;
    step();
    wait_sync(100);
    repeat (500) step();
    chk(s_err == 32'(exp_err), req, "errors around blank edge", s_err, exp_err);
    chk(s_bits == 32'(snap_tally), "R4", "bits counted after blank", s_bits, snap_tally);
    chk(s_nbits == 8'((snap_tally > 255) ? 255 : snap_tally), "R9", "narrow count saturates",
        s_nbits, (snap_tally > 255) ? 255 : snap_tally);
  endtask

  initial begin
    int drop_at, prev, base;
    bit dropped;
    step();
    chk(!sync && !period_done, "R11", "sync/done in reset", {sync, period_done}, 0);
    reset_dut(0, 1'b0, 0, 7);
    step();
    chk(!s_sync && !s_pd && s_err == 0 && s_bits == 0, "R11", "state after reset", s_bits, 0);
    chk(tx_valid && rx_ready, "R10", "valid/ready after reset", {tx_valid, rx_ready}, 3);

    // every length and direction: recurrence, acquisition, one clean window
    for (int p = 0; p < 4; p++) begin
      for (int r = 0; r < 2; r++) begin
        reset_dut(p, 1'(r), p % 3, 0);
        step();
        wait_sync(200);
        chk(s_sync && snap_rx >= 2 * n_b && snap_rx <= 3 * n_b, "R3", "acquisition bits",
            snap_rx, 2 * n_b);
        for (int i = 0; i < 2500 && !s_pd; i++) step();
        chk(s_pd && s_bits == 1000 && snap_tally == 1000, "R6", "window total",
            s_bits, 1000);
        chk(s_err == 0, "R5", "clean window errors", s_err, 0);
        chk(recur_bad == 0, r ? "R2" : "R1", "sequence recurrence", recur_bad, 0);
      end
    end

    // second decade
    reset_dut(0, 1'b0, 0, 1);
    step();
    for (int i = 0; i < 16000 && !s_pd; i++) step();
    chk(s_pd && s_bits == 10000 && snap_tally == 10000, "R6", "decade window", s_bits, 10000);
    step();
    chk(!s_pd, "R6", "done is one cycle", s_pd, 0);

    // blanking edge
    blank_run(0, 10, 0, "R4");
    blank_run(0, 40, 1, "R5");
    blank_run(1, 40, 0, "R4");

    // forced errors
    reset_dut(2, 1'b0, 0, 7);
    step();
    wait_sync(100);
    while (lock_idx < 50) step();
    force_err = 1'b1; repeat (3) step(); force_err = 1'b0;
    repeat (120) step();
    chk(s_err == 1, "R7", "one error per force edge", s_err, 1);
    force_err = 1'b1; repeat (2) step(); force_err = 1'b0;
    repeat (120) step();
    chk(s_err == 2, "R7", "second force edge", s_err, 2);

    // loss of sync
    reset_dut(1, 1'b0, 0, 7);
    step();
    wait_sync(100);
    flip_on = 1'b1; flip_lo = 100; flip_hi = 107;
    dropped = 1'b0;
    for (int i = 0; i < 400 && lock_idx < 150; i++) begin
      step();
      if (!s_sync) dropped = 1'b1;
    end
    chk(!dropped, "R8", "eight errors keep sync", dropped, 0);
    flip_lo = 200; flip_hi = 208; drop_at = -1;
    for (int i = 0; i < 400 && drop_at < 0; i++) begin
      prev = lock_idx;
      step();
      if (!s_sync) drop_at = prev;
    end
    chk(drop_at == 209, "R8", "ninth error drops sync", drop_at, 209);
    chk(s_err == 17, "R5", "errors before loss", s_err, 17);
    flip_on = 1'b0;
    base = snap_rx;
    wait_sync(200);
    chk(s_sync && snap_rx - base <= 3 * n_b, "R8", "reacquire after loss",
        snap_rx - base, 3 * n_b);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: R3 run did not end, actual 1 expected 0");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule